// File: doc/BRIEF.md
# Card Presence Debounce and Bus Guard

This block watches the raw card-presence pin of a removable memory card slot. It brings the pin into the clock domain through a synchronizer and waits for the level to stay still for a programmable number of clock cycles. It then reports two status bits: one that says the level has settled, and one that says a card is present and settled. A settled rise of the presence level produces a one-cycle arrival pulse. A settled fall produces a one-cycle departure pulse. An external status register is expected to latch both pulses.

The block also protects the card bus. The command and data line output enables from the protocol engine pass through only while a card is reported present. The enables drop as soon as the presence bit falls, which tri-states those lines. After a confirmed departure, the enables stay off until software issues a reset-all pulse. A departure that happens while bus power and the card clock are both on raises one-cycle clear pulses for those two control bits. The reset-all pulse does not disturb detection: the synchronizer, the debounce window and both status bits ignore it. Detection also runs whether or not bus power is on.

Top module: `card_detect_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `det_stable`, `card_inserted`, `ins_irq`, `rem_irq`, `cmd_oe`, `dat_oe`, `pwr_clr` and `sclk_clr` read 0 after that edge. `detect_raw` high means a card is present.
- R2: `detect_raw` passes through a two-stage synchronizer. A level change present at clock edge k is not seen by the debounce logic before edge k+2, so the status bits still hold their old values after edge k+1.
- R3: A level change of `detect_raw` first sampled at edge k drops `det_stable` after edge k+2. If the new level holds, `det_stable` rises again after edge k+2+DEBOUNCE_CYCLES, and the settled level takes the new value at that same edge.
- R4: Any change of the synchronized level restarts the debounce window. If the pin returns to its old level within the window, the settled level is unchanged and no interrupt pulse is produced.
- R5: `card_inserted` reads 1 only when `det_stable` is 1 and the settled level is present. It reads 0 during reset, during debouncing, and when no card is present.
- R6: A settled change from absent to present drives `ins_irq` high for exactly one cycle. A settled change from present to absent drives `rem_irq` high for exactly one cycle. The two pulses are never high together.
- R7: `cmd_oe` and `dat_oe` follow `cmd_oe_req` and `dat_oe_req` only while `card_inserted` is 1. They read 0 in the same cycle that `card_inserted` reads 0.
- R8: After a `rem_irq` pulse, `cmd_oe` and `dat_oe` stay 0, even if a card is inserted again, until a `sw_reset_all` pulse. They follow the requests again from the cycle after that pulse.
- R9: `pwr_clr` and `sclk_clr` pulse together with `rem_irq` when `bus_pwr_en` and `sd_clk_en` are both 1. Otherwise they stay 0.
- R10: `sw_reset_all` leaves `det_stable`, `card_inserted` and both interrupt outputs unchanged, and it does not restart a debounce window that is in progress.
- R11: Insertion is detected and signalled with `bus_pwr_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| detect_raw | input | 1 | Asynchronous card-presence pin, high when a card is present |
| sw_reset_all | input | 1 | One-cycle software reset-all request |
| bus_pwr_en | input | 1 | Current state of the card bus power control bit |
| sd_clk_en | input | 1 | Current state of the card clock enable control bit |
| cmd_oe_req | input | 1 | Command line output enable from the protocol engine |
| dat_oe_req | input | DAT_W | Data line output enables from the protocol engine |
| card_inserted | output | 1 | Card present and level settled |
| det_stable | output | 1 | Detect level settled, either present or absent |
| ins_irq | output | 1 | One-cycle insertion pulse |
| rem_irq | output | 1 | One-cycle removal pulse |
| cmd_oe | output | 1 | Gated command line output enable |
| dat_oe | output | DAT_W | Gated data line output enables |
| pwr_clr | output | 1 | One-cycle request to clear bus power |
| sclk_clr | output | 1 | One-cycle request to clear the card clock enable |

## Verification
The bench builds the block with DEBOUNCE_CYCLES set to 8, SYNC_STAGES to 2 and DAT_W to 4. The short window makes it possible to check the exact edge at which `det_stable` and the interrupt pulses change. It also allows a glitch shorter than the window and a reset-all pulse in the middle of a window to be placed on chosen cycles. The default window of 500000 cycles keeps the same logic but would only widen the waits.

// File: rtl/cdm_pkg.sv
// Package: shared types for the card-presence monitor.
// Assumes: nothing beyond a single clock domain for all users.
package cdm_pkg;

    // Debounced view of the presence pin handed from filter to guard.
    typedef struct packed {
        logic stable;   // level has held for a full window
        logic level;    // last settled level, 1 = present
    } det_state_t;

endpackage

// File: rtl/cdm_sync.sv
// Module: cdm_sync
// Brings an asynchronous single-bit pin into the clk domain through a
// shift chain of STAGES flops.
// Assumes: STAGES >= 2; d may change at any time relative to clk.
module cdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], d};
        end
    end

    assign q = chain_q[LAST];

    // R2: the first stage holds what the pin showed one edge earlier.
    a_r2_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> chain_q[0] == $past(d));

endmodule

// File: rtl/cdm_debounce.sv
// Module: cdm_debounce
// Waits for the synchronized presence level to stay unchanged for
// DEBOUNCE_CYCLES consecutive edges, then reports it as settled.
// Assumes: sync_lvl is already in the clk domain; DEBOUNCE_CYCLES >= 1.
module cdm_debounce
    import cdm_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_lvl,
    output det_state_t state
);

    localparam int CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic             lvl_q;      // level currently being timed
    logic [CNT_W-1:0] cnt_q;      // edges the level has held so far
    logic             stable_q;   // window complete
    logic             settled_q;  // last level that completed a window
    logic             changed;

    assign changed = (sync_lvl != lvl_q);

    // Track the timed level and restart the window on every change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (changed) begin
            lvl_q <= sync_lvl;
        end
    end

    // Count edges of an unchanged level until the window is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (changed) begin
            cnt_q <= '0;
        end else if (!stable_q && cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Declare the level settled once the window runs out; drop it on change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
        end else if (changed) begin
            stable_q <= 1'b0;
        end else if (!stable_q && cnt_q == CNT_LAST) begin
            stable_q <= 1'b1;
        end
    end

    // Capture the settled level at the edge the window completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settled_q <= 1'b0;
        end else if (!changed && !stable_q && cnt_q == CNT_LAST) begin
            settled_q <= lvl_q;
        end
    end

    assign state.stable = stable_q;
    assign state.level  = settled_q;

    // R4: a change of the synchronized level always reopens the window.
    a_r4_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> !stable_q);

    // R3: the settled level moves only at the edge the window completes.
    a_r3_level_moves_on_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (settled_q != $past(settled_q)) |-> $rose(stable_q));

    // R3: a window completes only on a level that held through the prior edge.
    a_r3_settle_on_held_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable_q) |-> $stable(lvl_q));

endmodule

// File: rtl/cdm_bus_guard.sv
// Module: cdm_bus_guard
// Turns the debounced presence state into status, edge pulses, gated bus
// output enables and power/clock clear pulses.
// Assumes: det is the registered output of cdm_debounce; sw_reset_all is a
// one-cycle pulse.
module cdm_bus_guard
    import cdm_pkg::*;
#(
    parameter int DAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  det_state_t       det,
    input  logic             sw_reset_all,
    input  logic             bus_pwr_en,
    input  logic             sd_clk_en,
    input  logic             cmd_oe_req,
    input  logic [DAT_W-1:0] dat_oe_req,
    output logic             card_inserted,
    output logic             ins_irq,
    output logic             rem_irq,
    output logic             cmd_oe,
    output logic [DAT_W-1:0] dat_oe,
    output logic             pwr_clr,
    output logic             sclk_clr
);

    logic level_d;     // settled level one edge ago
    logic lock_q;      // bus held off after a removal
    logic arrival;
    logic departure;
    logic drive_ok;

    // Remember the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= det.level;
        end
    end

    // Hold the bus off after a removal until software resets the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (departure) begin
            lock_q <= 1'b1;
        end else if (sw_reset_all) begin
            lock_q <= 1'b0;
        end
    end

    // Decode status and pulses from the registered state.
    always_comb begin
        arrival       = det.level & ~level_d;
        departure     = level_d & ~det.level;
        card_inserted = det.stable & det.level;
        drive_ok      = card_inserted & ~lock_q;
    end

    // Gate the protocol engine's output enables with presence and lock.
    always_comb begin
        cmd_oe = cmd_oe_req & drive_ok;
        dat_oe = dat_oe_req & {DAT_W{drive_ok}};
    end

    // Request power and clock shutdown on a removal with both running.
    always_comb begin
        pwr_clr  = departure & bus_pwr_en & sd_clk_en;
        sclk_clr = pwr_clr;
    end

    assign ins_irq = arrival;
    assign rem_irq = departure;

    // R6: the two interrupt pulses never coincide.
    a_r6_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_irq && rem_irq));

    // R6: each pulse lasts a single cycle.
    a_r6_ins_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ins_irq |=> !ins_irq);
    a_r6_rem_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rem_irq |=> !rem_irq);

    // R8: after a removal the bus stays undriven on the following cycle.
    a_r8_locked_after_removal: assert property (@(posedge clk) disable iff (!rst_n)
        rem_irq |=> (!cmd_oe && dat_oe == '0));

    // R9: clear requests appear only alongside a removal, and together.
    a_r9_clear_with_removal: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_clr || sclk_clr) |-> (rem_irq && pwr_clr && sclk_clr));

endmodule

// File: rtl/card_detect_monitor.sv
// Module: card_detect_monitor
// Top of the card-presence monitor: synchronizer, debounce filter and bus
// guard in a chain. Software reset-all reaches only the guard's lock.
// Assumes: one clock, synchronous active-low reset, detect_raw high = card.
module card_detect_monitor
    import cdm_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 500000,
    parameter int SYNC_STAGES     = 2,
    parameter int DAT_W           = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect_raw,
    input  logic             sw_reset_all,
    input  logic             bus_pwr_en,
    input  logic             sd_clk_en,
    input  logic             cmd_oe_req,
    input  logic [DAT_W-1:0] dat_oe_req,
    output logic             card_inserted,
    output logic             det_stable,
    output logic             ins_irq,
    output logic             rem_irq,
    output logic             cmd_oe,
    output logic [DAT_W-1:0] dat_oe,
    output logic             pwr_clr,
    output logic             sclk_clr
);

    logic       sync_lvl;
    det_state_t det;

    cdm_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (detect_raw),
        .q     (sync_lvl)
    );

    cdm_debounce #(
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_debounce (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .state    (det)
    );

    cdm_bus_guard #(
        .DAT_W (DAT_W)
    ) u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .det           (det),
        .sw_reset_all  (sw_reset_all),
        .bus_pwr_en    (bus_pwr_en),
        .sd_clk_en     (sd_clk_en),
        .cmd_oe_req    (cmd_oe_req),
        .dat_oe_req    (dat_oe_req),
        .card_inserted (card_inserted),
        .ins_irq       (ins_irq),
        .rem_irq       (rem_irq),
        .cmd_oe        (cmd_oe),
        .dat_oe        (dat_oe),
        .pwr_clr       (pwr_clr),
        .sclk_clr      (sclk_clr)
    );

    assign det_stable = det.stable;

    // R5: presence is never reported on an unsettled level.
    a_r5_inserted_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        card_inserted |-> det_stable);

    // R7: no line is driven while presence is not reported.
    a_r7_no_drive_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !card_inserted |-> (!cmd_oe && dat_oe == '0));

    // R10: a reset-all pulse does not pull a settled level back into debounce.
    a_r10_reset_all_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset_all && det_stable && sync_lvl == det.level) |=> det_stable);

endmodule

// File: tb/sim_card_detect_monitor.sv
// Directed bench for card_detect_monitor: one task per scenario.
module sim_card_detect_monitor;

    localparam int DB    = 8;
    localparam int DAT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             detect_raw = 1'b0;
    logic             sw_reset_all = 1'b0;
    logic             bus_pwr_en = 1'b0;
    logic             sd_clk_en = 1'b0;
    logic             cmd_oe_req = 1'b1;
    logic [DAT_W-1:0] dat_oe_req = 4'hF;
    logic             card_inserted, det_stable, ins_irq, rem_irq;
    logic             cmd_oe, pwr_clr, sclk_clr;
    logic [DAT_W-1:0] dat_oe;

    int checks = 0;
    int errors = 0;
    int ins_seen = 0;
    int rem_seen = 0;
    int clr_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    card_detect_monitor #(
        .DEBOUNCE_CYCLES (DB),
        .SYNC_STAGES     (2),
        .DAT_W           (DAT_W)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .detect_raw    (detect_raw),
        .sw_reset_all  (sw_reset_all),
        .bus_pwr_en    (bus_pwr_en),
        .sd_clk_en     (sd_clk_en),
        .cmd_oe_req    (cmd_oe_req),
        .dat_oe_req    (dat_oe_req),
        .card_inserted (card_inserted),
        .det_stable    (det_stable),
        .ins_irq       (ins_irq),
        .rem_irq       (rem_irq),
        .cmd_oe        (cmd_oe),
        .dat_oe        (dat_oe),
        .pwr_clr       (pwr_clr),
        .sclk_clr      (sclk_clr)
    );

    // Count pulses at the falling edge, away from register updates.
    always @(negedge clk) begin
        if (ins_irq) ins_seen++;
        if (rem_irq) rem_seen++;
        if (pwr_clr || sclk_clr) clr_seen++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance n falling edges and settle 1 ns past them.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_sw_reset();
        sw_reset_all = 1'b1;
        step(1);
        sw_reset_all = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        chk("R1", "stable in reset", 32'(det_stable), 0);
        chk("R1", "inserted in reset", 32'(card_inserted), 0);
        chk("R1", "oe in reset", 32'({cmd_oe, dat_oe}), 0);
        chk("R1", "irq in reset", 32'({ins_irq, rem_irq, pwr_clr, sclk_clr}), 0);
        rst_n = 1'b1;
        step(20);
        chk("R5", "stable with no card", 32'(det_stable), 1);
        chk("R5", "inserted with no card", 32'(card_inserted), 0);
        chk("R6", "no pulse at power-up", 32'(ins_seen + rem_seen), 0);
    endtask

    // Insertion with bus power off; exact settle edge.
    task automatic t_insert_unpowered();
        bus_pwr_en = 1'b0;
        sd_clk_en  = 1'b0;
        detect_raw = 1'b1;
        step(1);
        chk("R2", "stable one edge after pin rise", 32'(det_stable), 1);
        step(2);
        chk("R3", "stable drops after pin rise", 32'(det_stable), 0);
        step(DB - 1);
        chk("R3", "still debouncing at window-1", 32'(det_stable), 0);
        chk("R5", "not inserted while debouncing", 32'(card_inserted), 0);
        step(1);
        chk("R11", "insertion pulse without power", 32'(ins_irq), 1);
        chk("R5", "inserted after window", 32'(card_inserted), 1);
        chk("R7", "oe follows request", 32'({cmd_oe, dat_oe}), 32'h1F);
        step(1);
        chk("R6", "insertion pulse one cycle", 32'(ins_irq), 0);
        chk("R6", "one insertion pulse", 32'(ins_seen), 1);
    endtask

    task automatic t_sw_reset_when_present();
        pulse_sw_reset();
        step(3);
        chk("R10", "inserted after reset-all", 32'(card_inserted), 1);
        chk("R10", "stable after reset-all", 32'(det_stable), 1);
        chk("R10", "no pulse from reset-all", 32'(ins_seen + rem_seen), 1);
    endtask

    task automatic t_glitch();
        detect_raw = 1'b0;
        step(3);
        chk("R7", "oe off while debouncing", 32'({cmd_oe, dat_oe}), 0);
        chk("R5", "inserted low in glitch", 32'(card_inserted), 0);
        detect_raw = 1'b1;
        step(DB + 10);
        chk("R4", "inserted after glitch", 32'(card_inserted), 1);
        chk("R4", "no pulse from glitch", 32'(ins_seen + rem_seen), 1);
    endtask

    task automatic t_remove_powered();
        bus_pwr_en = 1'b1;
        sd_clk_en  = 1'b1;
        detect_raw = 1'b0;
        step(2);
        chk("R2", "inserted holds for sync", 32'(card_inserted), 1);
        step(1);
        chk("R7", "oe drops with inserted", 32'({cmd_oe, dat_oe}), 0);
        chk("R7", "inserted dropped", 32'(card_inserted), 0);
        step(DB);
        chk("R6", "removal pulse", 32'(rem_irq), 1);
        chk("R9", "power clear", 32'(pwr_clr), 1);
        chk("R9", "clock clear", 32'(sclk_clr), 1);
        step(1);
        chk("R6", "removal pulse one cycle", 32'(rem_irq), 0);
        chk("R9", "clear pulses one cycle", 32'(clr_seen), 1);
    endtask

    task automatic t_lock();
        bus_pwr_en = 1'b0;
        sd_clk_en  = 1'b0;
        detect_raw = 1'b1;
        step(DB + 3);
        chk("R8", "reinsertion seen", 32'(card_inserted), 1);
        chk("R8", "oe held off after removal", 32'({cmd_oe, dat_oe}), 0);
        pulse_sw_reset();
        chk("R8", "oe restored after reset-all", 32'({cmd_oe, dat_oe}), 32'h1F);
    endtask

    task automatic t_remove_clock_off();
        bus_pwr_en = 1'b1;
        sd_clk_en  = 1'b0;
        detect_raw = 1'b0;
        step(DB + 3);
        chk("R6", "removal pulse", 32'(rem_irq), 1);
        chk("R9", "no clear with clock off", 32'({pwr_clr, sclk_clr}), 0);
        step(2);
        chk("R9", "clear count unchanged", 32'(clr_seen), 1);
        pulse_sw_reset();
    endtask

    task automatic t_sw_reset_mid_window();
        bus_pwr_en = 1'b0;
        detect_raw = 1'b1;
        step(5);
        pulse_sw_reset();
        step(DB - 3);
        chk("R10", "window not restarted", 32'(ins_irq), 1);
        chk("R8", "drive after reset-all", 32'(cmd_oe), 1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_insert_unpowered();
        t_sw_reset_when_present();
        t_glitch();
        t_remove_powered();
        t_lock();
        t_remove_clock_off();
        t_sw_reset_mid_window();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule